// File: doc/BRIEF.md
# Rolling Activate Window Limiter

This block enforces a rolling limit on DRAM row activations: no more than X activates may fall inside any window of a set number of cycles, across every bank of every rank. It keeps a short shift history of the most recent activate timestamps. Each time the command side reports an activate, the block updates that history. It then works out the earliest cycle at which any bank may be activated again.

That earliest time is broadcast as a single bound. Each bank takes the larger of its own free time and this bound. The block also compares the bound with the free-running cycle counter and reports whether an activate is currently permitted. If a reported activate already breaks the window rule, the block raises a sticky violation flag.

Reported activate times may lie ahead of the current cycle, because the scheduler back-computes them from a bank's future free time. The window length and the activate count come from static configuration inputs.

Top module: `act_window_limiter`

## Requirements
- R1: After a synchronous active-high reset, `next_act_bound` is 0, `act_violation` is 0, and every history slot holds 0.
- R2: On an accepted activate, the block looks at the oldest of the last X recorded activates, which is the slot X-1 positions back before the new entry goes in. If that slot is non-zero and `act_time` minus it (unsigned) is less than `cfg_win`, `act_violation` is 1 from the next cycle.
- R3: Once set, `act_violation` stays 1 until reset, whatever later activates arrive.
- R4: A history slot holding 0 is empty. It never causes a violation or a bound update, and an activate reported at time 0 is stored as an empty slot.
- R5: Each accepted activate discards the oldest entry, shifts the rest by one place and stores `act_time` as the newest entry. The new oldest of X entries is the entry that was X-2 places back, or the new time itself when X is 1. If that entry is non-zero and `act_time` minus it is less than `cfg_win`, the bound becomes max(current bound, that entry + `cfg_win`) on the cycle after the strobe.
- R6: `next_act_bound` never decreases between resets.
- R7: A difference exactly equal to `cfg_win` is not inside the window: it neither sets the violation nor moves the bound.
- R8: `act_ok` is 1 exactly when `now` >= `next_act_bound` (unsigned).
- R9: The effective X is `cfg_limit` limited to the range 1..MAX_X. A value of 0 acts as 1, and a value above MAX_X (default 8) acts as MAX_X.
- R10: In a cycle without `act_valid`, the bound and the violation flag keep their values, whatever `act_time` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | One activate reported this cycle |
| act_time | input | TS_W (32) | Cycle stamp of the reported activate |
| now | input | TS_W (32) | Free-running cycle counter |
| cfg_win | input | WIN_W (16) | Window length in cycles |
| cfg_limit | input | XW (4) | Activates allowed per window (X) |
| next_act_bound | output | TS_W (32) | Earliest cycle any bank may activate next |
| act_violation | output | 1 | Sticky window-rule violation flag |
| act_ok | output | 1 | Counter has reached the bound |

## Verification
The activate stream is tried in several shapes, and each one exposes a different fault. A slow fill of the history shows that empty slots do not constrain; a burst of closely spaced activates exercises both the bound and the violation; and stamps spaced exactly one window apart, or one cycle short of it, separate the less-than test from a less-or-equal test. Runs with X set to 0 and to a value above the maximum check the clamping, because the bound then appears after a different number of activates. A zero timestamp in the stream shows that empty slots are skipped, and idle cycles with a changing `act_time` show that nothing moves without a strobe.

// File: rtl/awl_pkg.sv
package awl_pkg;
   localparam int unsigned AWL_LIMIT_CAP = 8;

   function automatic int unsigned awl_idx_w(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/awl_history.sv
module awl_history #(
   parameter int TS_W  = 32,
   parameter int DEPTH = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        push,
   input  logic [TS_W-1:0]             din,
   output logic [DEPTH-1:0][TS_W-1:0]  slots
);
   // slot 0 is the newest entry, slot DEPTH-1 the oldest
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)       slots[0] <= '0;
            else if (push) slots[0] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst)       slots[i] <= '0;
            else if (push) slots[i] <= slots[i-1];
         end
      end
   end
endmodule

// File: rtl/awl_window_tap.sv
module awl_window_tap #(
   parameter int TS_W  = 32,
   parameter int WIN_W = 16,
   parameter int DEPTH = 8,
   parameter int IW    = 3
) (
   input  logic [DEPTH-1:0][TS_W-1:0]  slots,
   input  logic [IW-1:0]               sel,
   input  logic                        use_newest,
   input  logic [TS_W-1:0]             newest,
   input  logic [WIN_W-1:0]            win,
   output logic [TS_W-1:0]             oldest,
   output logic                        hit
);
   logic [TS_W-1:0] picked;
   logic [TS_W-1:0] gap;

   always_comb begin
      picked = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (sel == IW'(i)) picked = slots[i];
      end
   end

   assign oldest = use_newest ? newest : picked;
   assign gap    = newest - oldest;
   assign hit    = (oldest != '0) && (gap < TS_W'(win));
endmodule

// File: rtl/awl_bound.sv
module awl_bound #(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            upd,
   input  logic [TS_W-1:0] cand,
   output logic [TS_W-1:0] bound
);
   always_ff @(posedge clk) begin
      if (rst)                        bound <= '0;
      else if (upd && (cand > bound)) bound <= cand;
   end
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter
   import awl_pkg::*;
#(
   parameter int TS_W  = 32,
   parameter int WIN_W = 16,
   parameter int MAX_X = 8,
   localparam int XW   = $clog2(MAX_X + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              act_valid,
   input  logic [TS_W-1:0]   act_time,
   input  logic [TS_W-1:0]   now,
   input  logic [WIN_W-1:0]  cfg_win,
   input  logic [XW-1:0]     cfg_limit,
   output logic [TS_W-1:0]   next_act_bound,
   output logic              act_violation,
   output logic              act_ok
);
   localparam int IW = awl_idx_w(MAX_X);

   initial begin
      assert (MAX_X >= 1 && MAX_X <= int'(AWL_LIMIT_CAP))
         else $error("MAX_X out of range");
      assert (WIN_W >= 1 && WIN_W <= TS_W)
         else $error("WIN_W must fit in TS_W");
   end

   logic [XW-1:0]               x_eff;
   logic [MAX_X-1:0][TS_W-1:0]  slots;
   logic [IW-1:0]               pre_sel;
   logic [IW-1:0]               post_sel;
   logic                        post_newest;
   logic [TS_W-1:0]             pre_oldest;
   logic [TS_W-1:0]             post_oldest;
   logic                        pre_hit;
   logic                        post_hit;
   logic [TS_W-1:0]             bound_cand;

   // limit the configured count to 1..MAX_X
   always_comb begin
      if (cfg_limit == '0)                 x_eff = XW'(1);
      else if (cfg_limit > XW'(MAX_X))     x_eff = XW'(MAX_X);
      else                                 x_eff = cfg_limit;
   end

   assign pre_sel = IW'(x_eff - XW'(1));

   if (MAX_X == 1) begin : g_single
      assign post_newest = 1'b1;
      assign post_sel    = '0;
   end else begin : g_multi
      assign post_newest = (x_eff == XW'(1));
      assign post_sel    = IW'(x_eff - XW'(2));
   end

   awl_history #(.TS_W(TS_W), .DEPTH(MAX_X)) u_hist (
      .clk   (clk),
      .rst   (rst),
      .push  (act_valid),
      .din   (act_time),
      .slots (slots)
   );

   // check against the oldest entry before the shift
   awl_window_tap #(.TS_W(TS_W), .WIN_W(WIN_W), .DEPTH(MAX_X), .IW(IW)) u_pre (
      .slots      (slots),
      .sel        (pre_sel),
      .use_newest (1'b0),
      .newest     (act_time),
      .win        (cfg_win),
      .oldest     (pre_oldest),
      .hit        (pre_hit)
   );

   // oldest entry as it will be after the shift
   awl_window_tap #(.TS_W(TS_W), .WIN_W(WIN_W), .DEPTH(MAX_X), .IW(IW)) u_post (
      .slots      (slots),
      .sel        (post_sel),
      .use_newest (post_newest),
      .newest     (act_time),
      .win        (cfg_win),
      .oldest     (post_oldest),
      .hit        (post_hit)
   );

   assign bound_cand = post_oldest + TS_W'(cfg_win);

   awl_bound #(.TS_W(TS_W)) u_bound (
      .clk   (clk),
      .rst   (rst),
      .upd   (act_valid && post_hit),
      .cand  (bound_cand),
      .bound (next_act_bound)
   );

   always_ff @(posedge clk) begin
      if (rst)                       act_violation <= 1'b0;
      else if (act_valid && pre_hit) act_violation <= 1'b1;
   end

   assign act_ok = (now >= next_act_bound);

   logic unused_ok;
   assign unused_ok = ^pre_oldest;
endmodule

// File: rtl/awl_checker.sv
module awl_checker #(
   parameter int TS_W = 32
) (
   input logic            clk,
   input logic            rst,
   input logic            act_valid,
   input logic [TS_W-1:0] next_act_bound,
   input logic            act_violation
);
   // R3: violation flag is sticky
   p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      act_violation |=> act_violation);

   // R2: violation only rises after an accepted activate
   p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(act_violation) |-> $past(act_valid));

   // R6: bound never moves backwards
   p_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
      next_act_bound >= $past(next_act_bound));

   // R10: without a strobe the bound holds
   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !act_valid |=> $stable(next_act_bound));

   // R5: the bound only moves on the cycle after a strobe
   p_move_cause_r5: assert property (@(posedge clk) disable iff (rst)
      !$stable(next_act_bound) |-> $past(act_valid));
endmodule

bind act_window_limiter awl_checker #(.TS_W(TS_W)) u_awl_checker (
   .clk            (clk),
   .rst            (rst),
   .act_valid      (act_valid),
   .next_act_bound (next_act_bound),
   .act_violation  (act_violation)
);

// File: tb/act_window_limiter_bench.sv
module act_window_limiter_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        act_valid = 1'b0;
   logic [31:0] act_time = '0;
   logic [31:0] now = '0;
   logic [15:0] cfg_win = 16'd100;
   logic [3:0]  cfg_limit = 4'd4;
   logic [31:0] next_act_bound;
   logic        act_violation;
   logic        act_ok;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   act_window_limiter u_act_window_limiter (
      .clk            (clk),
      .rst            (rst),
      .act_valid      (act_valid),
      .act_time       (act_time),
      .now            (now),
      .cfg_win        (cfg_win),
      .cfg_limit      (cfg_limit),
      .next_act_bound (next_act_bound),
      .act_violation  (act_violation),
      .act_ok         (act_ok)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks = checks + 1;
      if (got !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic do_reset(input logic [3:0] lim, input logic [15:0] win);
      @(negedge clk);
      rst = 1'b1;
      act_valid = 1'b0;
      cfg_limit = lim;
      cfg_win = win;
      now = '0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // one strobe; results are sampled at the following negedge
   task automatic act(input logic [31:0] t);
      @(negedge clk);
      act_valid = 1'b1;
      act_time = t;
      @(negedge clk);
      act_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset(4'd4, 16'd100);
      chk("R1 bound", next_act_bound, 32'd0);
      chk("R1 violation", {31'd0, act_violation}, 32'd0);
      chk("R1 act_ok", {31'd0, act_ok}, 32'd1);
   endtask

   task automatic t_fill_and_burst();
      do_reset(4'd4, 16'd100);
      act(10); act(20); act(30);
      chk("R4 partial fill bound", next_act_bound, 32'd0);
      act(40);
      chk("R5 bound after 4th", next_act_bound, 32'd110);
      chk("R2 no violation yet", {31'd0, act_violation}, 32'd0);
      act(150); act(300);
      chk("R6 bound kept", next_act_bound, 32'd110);
      act(320); act(330); act(340);
      chk("R5 bound raised", next_act_bound, 32'd400);
      chk("R2 still clean", {31'd0, act_violation}, 32'd0);
      act(350);
      chk("R2 violation set", {31'd0, act_violation}, 32'd1);
      chk("R5 bound 420", next_act_bound, 32'd420);
      act(1000);
      chk("R3 sticky", {31'd0, act_violation}, 32'd1);
      chk("R6 bound held", next_act_bound, 32'd420);
   endtask

   task automatic t_edge_spacing();
      do_reset(4'd4, 16'd100);
      act(100); act(110); act(120); act(200);
      chk("R7 gap equal window no bound", next_act_bound, 32'd0);
      act(210);
      chk("R7 gap equal again", next_act_bound, 32'd0);
      act(219);
      chk("R5 gap one short", next_act_bound, 32'd220);
      do_reset(4'd4, 16'd100);
      act(100); act(101); act(102); act(103);
      chk("R5 bound 200", next_act_bound, 32'd200);
      act(200);
      chk("R7 exact gap no violation", {31'd0, act_violation}, 32'd0);
      chk("R5 bound 201", next_act_bound, 32'd201);
      act(200);
      chk("R2 gap 99 violation", {31'd0, act_violation}, 32'd1);
   endtask

   task automatic t_zero_stamp();
      do_reset(4'd4, 16'd100);
      act(0); act(5); act(6); act(7);
      chk("R4 zero slot no bound", next_act_bound, 32'd0);
      act(8);
      chk("R4 zero slot no violation", {31'd0, act_violation}, 32'd0);
      chk("R5 bound 105", next_act_bound, 32'd105);
   endtask

   task automatic t_clamp();
      do_reset(4'd0, 16'd100);
      act(50);
      chk("R9 X=0 acts as 1 bound", next_act_bound, 32'd150);
      act(60);
      chk("R9 X=1 violation", {31'd0, act_violation}, 32'd1);
      chk("R9 X=1 bound", next_act_bound, 32'd160);
      do_reset(4'd12, 16'd100);
      for (int k = 1; k <= 7; k++) act(32'(k * 10));
      chk("R9 X>max seven acts", next_act_bound, 32'd0);
      act(80);
      chk("R9 X>max eighth act", next_act_bound, 32'd110);
   endtask

   task automatic t_idle_and_ok();
      do_reset(4'd4, 16'd100);
      act(10); act(20); act(30); act(40);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         act_time = 32'(15 + k);
      end
      chk("R10 bound held idle", next_act_bound, 32'd110);
      chk("R10 violation held idle", {31'd0, act_violation}, 32'd0);
      now = 32'd109;
      #1;
      chk("R8 before bound", {31'd0, act_ok}, 32'd0);
      now = 32'd110;
      #1;
      chk("R8 at bound", {31'd0, act_ok}, 32'd1);
   endtask

   initial begin
      t_reset();
      t_fill_and_burst();
      t_edge_spacing();
      t_zero_stamp();
      t_clamp();
      t_idle_and_ok();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule